// File: doc/BRIEF.md
# Serial Slave Front End with Pause Control

This block is the bit-level front end of a small serial memory slave. It samples the chip-select, serial clock, serial data-in and pause pins in the system clock domain through synchronizers, finds the serial clock edges from those samples, and turns the bit stream into bytes for a command layer. Incoming bits are taken on rising serial clock edges, most significant bit first; outgoing bits are changed only on falling edges. Both clock polarities in common use are accepted: clock idle low (mode 0) and clock idle high (mode 3).

Towards the command layer it gives a one-cycle byte-valid strobe with the assembled byte and a flag marking the first byte of a frame (the instruction byte), a start-of-frame pulse and an end-of-frame pulse that says whether the frame ended on a byte boundary. The command layer presents the next byte to send on a parallel input, which is taken at the start of a frame and after each completed byte. The serial output is modelled as a data bit plus an output enable.

The pause pin freezes a transfer mid-byte: bit position, partial input byte and output shift state are kept, the output enable drops and clock and data activity is ignored. Entering and leaving the pause both wait for the serial clock to be low, so a deferred pause takes effect at the next low phase.

Top module: `spi_hold_fe`

## Requirements
- R1: Each rising serial clock edge in a frame shifts the data-in bit into the receive byte, MSB first; after every 8th rising edge `rx_valid_o` pulses for one cycle with the assembled byte on `rx_byte_o`.
- R2: `rx_first_o`, valid with `rx_valid_o`, is 1 for the first byte completed after chip select falls and 0 for every later byte of the frame.
- R3: When chip select falls, bit 7 of `tx_byte_i` appears on `sdo_o`; each later falling edge moves to the next lower bit, and the falling edge after the 8th rising edge of a byte shows bit 7 of the then-current `tx_byte_i`.
- R4: In mode 3 the leading falling edge of a frame (before any rising edge) leaves `sdo_o` unchanged, so both modes send the same bit sequence.
- R5: `sdo_oe_o` is 1 while chip select is low and the block is not paused, and 0 otherwise.
- R6: `sof_o` pulses once when chip select falls; `eof_o` pulses once when it rises, with `eof_aligned_o` = 1 exactly when the count of rising edges in the frame is a multiple of 8.
- R7: Chip select going high discards a partial byte; the next frame starts at bit 7 with the first-byte flag set.
- R8: A pause starts only when the pause pin is low while the serial clock is low; while paused, clock and data-in edges change nothing and the byte resumes at the bit where it stopped.
- R9: A pause pin change made while the serial clock is high takes effect only once the clock is low, for both entry and exit.
- R10: After reset, `sdo_oe_o`, `rx_valid_o`, `sof_o` and `eof_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| hold_ni | input | 1 | Pause request, active low |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the serial data out pad |
| rx_byte_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for a received byte |
| rx_first_o | output | 1 | Received byte is the first of the frame |
| tx_byte_i | input | 8 | Next byte to send |
| sof_o | output | 1 | Start-of-frame pulse |
| eof_o | output | 1 | End-of-frame pulse |
| eof_aligned_o | output | 1 | Frame ended on a byte boundary, valid with `eof_o` |

## Verification
The bench builds the block with its defaults: 8-bit bytes and two synchronizer stages. At that width every one of the 256 receive byte values is sent in both clock modes, each frame paired with a computed transmit pattern, so every bit position of both shift paths and the mode 3 leading edge are covered. Directed frames then cover a pause entered and left with the clock high, an aborted partial byte and the frame that follows it.

// File: rtl/spi_hold_fe_pkg.sv
package spi_hold_fe_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic cs_n;
    logic sck;
    logic sdi;
    logic hold_n;
  } pins_t;

  localparam int unsigned PIN_W = $bits(pins_t);
  // idle levels: deselected, clock low, data low, no pause
  localparam pins_t PINS_IDLE = '{cs_n: 1'b1, sck: 1'b0, sdi: 1'b0, hold_n: 1'b1};
endpackage

// File: rtl/spi_hold_fe_sync.sv
module spi_hold_fe_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[b]}};
      else if (STAGES == 1) chain_q <= d_i[b];
      else chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/spi_hold_fe_ctrl.sv
module spi_hold_fe_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_s_i,
  input  logic sck_s_i,
  input  logic hold_s_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o,
  output logic held_o,
  output logic active_o,
  output logic sof_o
);
  logic cs_d_q, sck_d_q, held_q, sof_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d_q  <= 1'b1;
      sck_d_q <= 1'b0;
    end else begin
      cs_d_q  <= cs_s_i;
      sck_d_q <= sck_s_i;
    end
  end

  assign start_o  = cs_d_q & ~cs_s_i;
  assign stop_o   = ~cs_d_q & cs_s_i;
  assign active_o = ~cs_s_i;

  // pause entry and exit both qualified on the clock being low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            held_q <= 1'b0;
    else if (cs_s_i)                        held_q <= 1'b0;
    else if (!held_q && !hold_s_i && !sck_s_i) held_q <= 1'b1;
    else if (held_q && hold_s_i && !sck_s_i)   held_q <= 1'b0;
  end

  assign held_o = held_q;
  assign rise_o = active_o & ~held_q & sck_s_i & ~sck_d_q;
  assign fall_o = active_o & ~held_q & ~sck_s_i & sck_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sof_q <= 1'b0;
    else         sof_q <= start_o;
  end
  assign sof_o = sof_q;

  AST_HOLD_ENTRY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(held_q) |-> $past(!sck_s_i && !hold_s_i)); // R8
  AST_HOLD_EXIT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(held_q) |-> $past(!sck_s_i || cs_s_i)); // R9
  AST_SOF_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_q |=> !sof_q); // R6
endmodule

// File: rtl/spi_hold_fe_shift.sv
module spi_hold_fe_shift #(
  parameter int unsigned W = 8,
  localparam int unsigned CNT_W = (W > 1) ? $clog2(W) : 1,
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             sdi_i,
  input  logic [W-1:0]     tx_byte_i,
  output logic [W-1:0]     rx_byte_o,
  output logic             rx_valid_o,
  output logic             rx_first_o,
  output logic             sdo_o,
  output logic             eof_o,
  output logic             eof_aligned_o,
  output logic [CNT_W-1:0] bit_cnt_o
);
  logic [CNT_W-1:0] bit_cnt_q;
  logic [W-1:0]     rx_sh_q, rx_byte_q, tx_sh_q;
  logic             rx_valid_q, rx_first_q, seen_rise_q, got_byte_q;
  logic             eof_q, aligned_q;
  logic [W-1:0]     rx_next;

  assign rx_next = {rx_sh_q[W-2:0], sdi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q   <= '0;
      rx_sh_q     <= '0;
      rx_byte_q   <= '0;
      tx_sh_q     <= '0;
      rx_valid_q  <= 1'b0;
      rx_first_q  <= 1'b0;
      seen_rise_q <= 1'b0;
      got_byte_q  <= 1'b0;
      eof_q       <= 1'b0;
      aligned_q   <= 1'b0;
    end else begin
      rx_valid_q <= 1'b0;
      eof_q      <= 1'b0;
      if (stop_i) begin
        eof_q       <= 1'b1;
        aligned_q   <= (bit_cnt_q == '0);
        bit_cnt_q   <= '0;
        seen_rise_q <= 1'b0;
        got_byte_q  <= 1'b0;
      end else if (start_i) begin
        tx_sh_q     <= tx_byte_i;
        bit_cnt_q   <= '0;
        seen_rise_q <= 1'b0;
        got_byte_q  <= 1'b0;
      end else begin
        if (rise_i) begin
          rx_sh_q     <= rx_next;
          seen_rise_q <= 1'b1;
          if (bit_cnt_q == LAST) begin
            bit_cnt_q  <= '0;
            rx_byte_q  <= rx_next;
            rx_valid_q <= 1'b1;
            rx_first_q <= ~got_byte_q;
            got_byte_q <= 1'b1;
          end else begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end
        end
        // a falling edge before any rising edge is the mode 3 lead-in
        if (fall_i && seen_rise_q) begin
          if (bit_cnt_q == '0) tx_sh_q <= tx_byte_i;
          else                 tx_sh_q <= {tx_sh_q[W-2:0], 1'b0};
        end
      end
    end
  end

  assign rx_byte_o     = rx_byte_q;
  assign rx_valid_o    = rx_valid_q;
  assign rx_first_o    = rx_first_q;
  assign sdo_o         = tx_sh_q[W-1];
  assign eof_o         = eof_q;
  assign eof_aligned_o = aligned_q;
  assign bit_cnt_o     = bit_cnt_q;

  AST_RX_AFTER_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_q |-> $past(rise_i)); // R1
  AST_SDO_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tx_sh_q[W-1]) |-> $past(fall_i || start_i)); // R3
  AST_EOF_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_q |=> !eof_q); // R6
  AST_FIRST_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_q && !stop_i && !start_i) |-> got_byte_q); // R2
endmodule

// File: rtl/spi_hold_fe.sv
module spi_hold_fe
  import spi_hold_fe_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic              hold_ni,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  output logic              rx_first_o,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic              sof_o,
  output logic              eof_o,
  output logic              eof_aligned_o
);
  localparam int unsigned CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

  pins_t pins_raw, pins_s;
  logic  start, stop, rise, fall, held, active;
  logic [CNT_W-1:0] bit_cnt;

  assign pins_raw = '{cs_n: cs_ni, sck: sck_i, sdi: sdi_i, hold_n: hold_ni};

  spi_hold_fe_sync #(
    .W       (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PINS_IDLE)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pins_raw),
    .q_o    (pins_s)
  );

  spi_hold_fe_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_s_i   (pins_s.cs_n),
    .sck_s_i  (pins_s.sck),
    .hold_s_i (pins_s.hold_n),
    .start_o  (start),
    .stop_o   (stop),
    .rise_o   (rise),
    .fall_o   (fall),
    .held_o   (held),
    .active_o (active),
    .sof_o    (sof_o)
  );

  spi_hold_fe_shift #(.W(BYTE_W)) u_shift (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start),
    .stop_i        (stop),
    .rise_i        (rise),
    .fall_i        (fall),
    .sdi_i         (pins_s.sdi),
    .tx_byte_i     (tx_byte_i),
    .rx_byte_o     (rx_byte_o),
    .rx_valid_o    (rx_valid_o),
    .rx_first_o    (rx_first_o),
    .sdo_o         (sdo_o),
    .eof_o         (eof_o),
    .eof_aligned_o (eof_aligned_o),
    .bit_cnt_o     (bit_cnt)
  );

  assign sdo_oe_o = active & ~held;

  AST_HOLD_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held && !stop) |=> $stable(bit_cnt)); // R8
  AST_SOF_EOF_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sof_o && eof_o)); // R6
  AST_OE_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |-> !sdo_oe_o); // R5
endmodule

// File: tb/spi_hold_fe_bench.sv
module spi_hold_fe_bench;
  localparam int HP = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, hold_n = 1'b1;
  logic [7:0] tx_byte = '0;
  logic sdo, sdo_oe, rx_valid, rx_first, sof, eof, eof_al;
  logic [7:0] rx_byte;

  int n_chk = 0, n_fail = 0;
  int n_rx = 0, n_sof = 0, n_eof = 0;
  logic [7:0] rxq [0:1023];
  logic       fq  [0:1023];
  logic       last_al = 1'b0;

  always #5 clk = ~clk;

  spi_hold_fe u_spi_hold_fe (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .sdi_i(sdi),
    .hold_ni(hold_n), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .rx_byte_o(rx_byte),
    .rx_valid_o(rx_valid), .rx_first_o(rx_first), .tx_byte_i(tx_byte),
    .sof_o(sof), .eof_o(eof), .eof_aligned_o(eof_al)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      rxq[n_rx % 1024] = rx_byte;
      fq[n_rx % 1024]  = rx_first;
      n_rx++;
    end
    if (sof) n_sof++;
    if (eof) begin
      n_eof++;
      last_al = eof_al;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (HP) @(negedge clk);
  endtask

  task automatic frame_begin(input bit mode3, input logic [7:0] tx0);
    sck = mode3;
    tx_byte = tx0;
    half();
    cs_n = 1'b0;
    half(); half();
  endtask

  task automatic frame_end(input bit mode3);
    if (!mode3) begin sck = 1'b0; half(); end
    cs_n = 1'b1;
    half(); half();
  endtask

  task automatic send_bit(input logic b, input logic exp_so, input string req);
    sck = 1'b0; sdi = b;
    half();
    chk(sdo === exp_so, req, sdo, exp_so);
    sck = 1'b1;
    half();
  endtask

  task automatic xfer(input logic [7:0] mo, input logic [7:0] tx_now,
                      input logic [7:0] tx_next, input string req);
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; sdi = mo[i];
      half();
      got[i] = sdo;
      sck = 1'b1;
      if (i == 0) tx_byte = tx_next;
      half();
    end
    chk(got === tx_now, req, got, tx_now);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(sdo_oe === 1'b0, "R10 oe", sdo_oe, 0);
    chk(rx_valid === 1'b0, "R10 valid", rx_valid, 0);
    chk(sof === 1'b0 && eof === 1'b0, "R10 sof/eof", {sof, eof}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // exhaustive byte sweep in both modes: R1 R2 R3 R4 R6
    for (int m = 0; m < 2; m++) begin
      for (int v = 0; v < 256; v++) begin
        logic [7:0] b0, b1, t0, t1;
        int rx0, sof0, eof0;
        b0 = v[7:0];
        b1 = ~v[7:0] ^ 8'(m * 8'h5A);
        t0 = 8'(v * 37 + 11);
        t1 = 8'(v * 13 + 200);
        rx0 = n_rx; sof0 = n_sof; eof0 = n_eof;
        frame_begin(m[0], t0);
        chk(sdo_oe === 1'b1, "R5 oe in frame", sdo_oe, 1);
        xfer(b0, t0, t1, m ? "R4 mode3 tx byte0" : "R3 mode0 tx byte0");
        xfer(b1, t1, 8'h00, "R3 tx byte1");
        frame_end(m[0]);
        chk(sdo_oe === 1'b0, "R5 oe deselected", sdo_oe, 0);
        chk(n_rx == rx0 + 2, "R1 byte count", n_rx - rx0, 2);
        chk(rxq[rx0 % 1024] === b0, "R1 rx byte0", rxq[rx0 % 1024], b0);
        chk(rxq[(rx0 + 1) % 1024] === b1, "R1 rx byte1", rxq[(rx0 + 1) % 1024], b1);
        chk(fq[rx0 % 1024] === 1'b1 && fq[(rx0 + 1) % 1024] === 1'b0, "R2 first flag",
            {fq[rx0 % 1024], fq[(rx0 + 1) % 1024]}, 2'b10);
        chk(n_sof == sof0 + 1 && n_eof == eof0 + 1, "R6 sof/eof count",
            (n_sof - sof0) * 16 + (n_eof - eof0), 8'h11);
        chk(last_al === 1'b1, "R6 aligned", last_al, 1);
      end
    end

    // pause with deferred entry and exit: R8 R9
    begin
      int rx0;
      logic [7:0] t;
      t = 8'h3C;
      rx0 = n_rx;
      frame_begin(1'b0, t);
      send_bit(1'b1, t[7], "R8 pre-pause bit7");
      send_bit(1'b0, t[6], "R8 pre-pause bit6");
      send_bit(1'b1, t[5], "R8 pre-pause bit5");
      hold_n = 1'b0;
      half();
      chk(sdo_oe === 1'b1, "R9 entry deferred while clock high", sdo_oe, 1);
      sck = 1'b0;
      half();
      chk(sdo_oe === 1'b0, "R8 paused oe", sdo_oe, 0);
      for (int k = 0; k < 3; k++) begin
        sck = 1'b1; sdi = ~sdi; half();
        sck = 1'b0; half();
      end
      chk(sdo_oe === 1'b0, "R8 still paused", sdo_oe, 0);
      chk(n_rx == rx0, "R8 no byte while paused", n_rx - rx0, 0);
      sck = 1'b1; half();
      hold_n = 1'b1; half();
      chk(sdo_oe === 1'b0, "R9 exit deferred while clock high", sdo_oe, 0);
      sck = 1'b0; half();
      chk(sdo_oe === 1'b1, "R9 resumed oe", sdo_oe, 1);
      chk(sdo === t[4], "R8 sdo kept", sdo, t[4]);
      send_bit(1'b0, t[4], "R8 resume bit4");
      send_bit(1'b0, t[3], "R8 resume bit3");
      send_bit(1'b1, t[2], "R8 resume bit2");
      send_bit(1'b0, t[1], "R8 resume bit1");
      send_bit(1'b1, t[0], "R8 resume bit0");
      frame_end(1'b0);
      chk(n_rx == rx0 + 1, "R8 one byte", n_rx - rx0, 1);
      chk(rxq[rx0 % 1024] === 8'hA5, "R8 byte across pause", rxq[rx0 % 1024], 8'hA5);
      chk(last_al === 1'b1, "R6 aligned after pause", last_al, 1);
    end

    // abort mid-byte, then a clean frame: R6 R7
    begin
      int rx0;
      rx0 = n_rx;
      frame_begin(1'b0, 8'hF0);
      for (int k = 0; k < 5; k++) send_bit(1'b1, k < 4 ? 1'b1 : 1'b0, "R3 abort frame sdo");
      frame_end(1'b0);
      chk(n_rx == rx0, "R7 partial byte dropped", n_rx - rx0, 0);
      chk(last_al === 1'b0, "R6 unaligned end", last_al, 0);
      frame_begin(1'b0, 8'h96);
      xfer(8'h81, 8'h96, 8'h00, "R7 tx after abort");
      frame_end(1'b0);
      chk(n_rx == rx0 + 1, "R7 count after abort", n_rx - rx0, 1);
      chk(rxq[rx0 % 1024] === 8'h81, "R7 byte after abort", rxq[rx0 % 1024], 8'h81);
      chk(fq[rx0 % 1024] === 1'b1, "R7 first flag after abort", fq[rx0 % 1024], 1);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule